// File: doc/BRIEF.md
# Processor Interrupt Entry Controller

This block sits next to a small 32-bit CPU core and decides when an interrupt is taken. It watches three kinds of source: a system reset request, one non-maskable interrupt (NMI) line, and a set of maskable interrupt lines (six by default). The core supplies its current program counter, processor status word (PSW) and cause register. When the block accepts a request, it tells the core where to go and what to save. It raises a one-cycle redirect strobe with the target address. Alongside the strobe it gives the new PSW and cause values and, where the source calls for it, a write strobe and contents for one pair of backup registers.

Requests may be single-cycle pulses or held levels. Each source is latched until it is accepted, so a pulse that arrives while it is masked is not lost. NMIs that arrive while one is already being handled collapse into a single held request. The core is expected to load the offered values on the strobe cycle. The block accepts nothing while its strobe is high, so its next decision always sees the updated PSW.

Top module: `irq_entry_ctrl`

## Requirements
- R1: A reset request beats every other source, including a busy cycle. One clock later the block redirects to address 0 with PSW 0x00000020 and cause 0, writes no backup register, and drops every held NMI and maskable request.
- R2: An NMI is accepted only when PSW bit 7 (NMI-pending) is clear, whatever the state of bit 5 (interrupt-disable). On acceptance the redirect address is 0x10 and the NMI backup strobe writes the sampled PC and PSW.
- R3: On NMI acceptance the offered cause is 0x0010 in bits 31:16, with bits 15:0 taken from the current cause. The offered PSW is the current PSW with bits 7 and 5 set and bit 6 (exception flag) cleared.
- R4: An NMI that arrives while bit 7 is set is held as a single request. Any number of further NMI pulses in that time yield exactly one delivery, once bit 7 reads clear.
- R5: A maskable request is accepted only when PSW bits 7 and 5 are both clear. Until then it stays latched and is retried on every cycle.
- R6: On maskable acceptance the interrupt backup strobe writes the sampled PC and PSW. The offered PSW is the current PSW with bit 5 set and bit 6 cleared, and the offered cause keeps bits 31:16 and puts the vector in bits 15:0.
- R7: Line i has vector 0x80 + 0x10*i (0x80 through 0xD0 for six lines). That value is used as the redirect address and as the lower cause half. When several lines are held, the lowest index wins and the others stay held.
- R8: When an NMI and a maskable request could both be taken in the same cycle, the NMI is taken and the maskable request stays held.
- R9: All outputs are registered and appear one clock after the sampling edge. The redirect strobe lasts one cycle, and no request is accepted on the edge that ends a strobe cycle.
- R10: When the redirect strobe is low, every value output and both backup strobes are zero. At most one backup strobe is high at a time.
- R11: The synchronous reset clears every held request and drives all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| reset_req | input | 1 | System reset request (highest precedence) |
| nmi_req | input | 1 | Non-maskable interrupt request |
| irq_req | input | NUM_IRQ | Maskable interrupt requests, bit i is line i |
| cur_pc | input | 32 | Core's current program counter |
| cur_psw | input | 32 | Core's current status word |
| cur_cause | input | 32 | Core's current cause register |
| redirect_valid | output | 1 | One-cycle strobe: take the values below |
| redirect_pc | output | 32 | Target address |
| psw_next | output | 32 | PSW to load |
| cause_next | output | 32 | Cause register to load |
| nmi_bk_we | output | 1 | Write strobe for the NMI backup pair |
| nmi_bk_pc | output | 32 | PC to save for the NMI |
| nmi_bk_psw | output | 32 | PSW to save for the NMI |
| irq_bk_we | output | 1 | Write strobe for the maskable backup pair |
| irq_bk_pc | output | 32 | PC to save for the maskable interrupt |
| irq_bk_psw | output | 32 | PSW to save for the maskable interrupt |

## Verification
Every result is due exactly one clock after the edge that samples the request together with the core's PC, PSW and cause. The one exception is the cycle right after a strobe, when nothing may be accepted. The bench changes inputs only on falling edges and steps its behavioural model on the same rising edge the design samples. It compares all ten outputs at the next falling edge, so a request that is held for many cycles is compared on every one of those cycles, not only when it is delivered. The bench also plays the role of the core and loads the offered PSW on each strobe, which shows whether masking takes effect on the following decision.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int XLEN        = 32;
    localparam int PSW_ID_BIT  = 5;
    localparam int PSW_EP_BIT  = 6;
    localparam int PSW_NP_BIT  = 7;

    typedef logic [XLEN-1:0] word_t;

    localparam word_t      RESET_PC     = '0;
    localparam word_t      RESET_PSW    = 32'h0000_0020;
    localparam word_t      NMI_TARGET   = 32'h0000_0010;
    localparam logic [15:0] NMI_CAUSE   = 16'h0010;
    localparam int         IRQ_VEC_BASE = 'h80;
    localparam int         IRQ_VEC_STEP = 'h10;

    typedef enum logic [1:0] {
        TAKE_NONE,
        TAKE_RESET,
        TAKE_NMI,
        TAKE_IRQ
    } take_e;

    typedef struct packed {
        logic  redirect;
        word_t pc;
        word_t psw;
        word_t cause;
        logic  nmi_we;
        word_t nmi_pc;
        word_t nmi_psw;
        logic  irq_we;
        word_t irq_pc;
        word_t irq_psw;
    } entry_t;

    function automatic logic [15:0] irq_vector(input int idx);
        return 16'(IRQ_VEC_BASE + IRQ_VEC_STEP * idx);
    endfunction

    function automatic word_t psw_on_nmi(input word_t p);
        word_t r;
        r = p;
        r[PSW_NP_BIT] = 1'b1;
        r[PSW_ID_BIT] = 1'b1;
        r[PSW_EP_BIT] = 1'b0;
        return r;
    endfunction

    function automatic word_t psw_on_irq(input word_t p);
        word_t r;
        r = p;
        r[PSW_ID_BIT] = 1'b1;
        r[PSW_EP_BIT] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/intc_pending.sv
module intc_pending #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_all,
    input  logic [W-1:0] req,
    input  logic [W-1:0] take,
    output logic [W-1:0] eff
);

    generate
        for (genvar i = 0; i < W; i++) begin : g_line
            logic held;
            always_ff @(posedge clk) begin
                if (rst || clr_all)
                    held <= 1'b0;
                else
                    held <= (held | req[i]) & ~take[i];
            end
            assign eff[i] = held | req[i];
        end
    endgenerate

endmodule

// File: rtl/intc_select.sv
module intc_select
    import intc_pkg::*;
#(
    parameter int N = 6
) (
    input  logic         reset_req,
    input  logic         busy,
    input  logic         np_flag,
    input  logic         id_flag,
    input  logic         nmi_eff,
    input  logic [N-1:0] irq_eff,
    output take_e        kind,
    output logic [N-1:0] grant
);

    logic [N:0]   seen;
    logic [N-1:0] first;

    assign seen[0] = 1'b0;
    generate
        for (genvar i = 0; i < N; i++) begin : g_prio
            assign first[i]  = irq_eff[i] & ~seen[i];
            assign seen[i+1] = seen[i] | irq_eff[i];
        end
    endgenerate

    always_comb begin
        if (reset_req)
            kind = TAKE_RESET;
        else if (busy)
            kind = TAKE_NONE;
        else if (nmi_eff && !np_flag)
            kind = TAKE_NMI;
        else if (seen[N] && !np_flag && !id_flag)
            kind = TAKE_IRQ;
        else
            kind = TAKE_NONE;
    end

    assign grant = (kind == TAKE_IRQ) ? first : '0;

endmodule

// File: rtl/intc_frame.sv
module intc_frame
    import intc_pkg::*;
#(
    parameter int N = 6
) (
    input  take_e        kind,
    input  logic [N-1:0] grant,
    input  word_t        cur_pc,
    input  word_t        cur_psw,
    input  word_t        cur_cause,
    output entry_t       ent
);

    logic [15:0] vec;

    always_comb begin
        vec = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i])
                vec = vec | irq_vector(i);
        end
    end

    always_comb begin
        ent = '0;
        case (kind)
            TAKE_RESET: begin
                ent.redirect = 1'b1;
                ent.pc       = RESET_PC;
                ent.psw      = RESET_PSW;
                ent.cause    = '0;
            end
            TAKE_NMI: begin
                ent.redirect = 1'b1;
                ent.pc       = NMI_TARGET;
                ent.psw      = psw_on_nmi(cur_psw);
                ent.cause    = {NMI_CAUSE, cur_cause[15:0]};
                ent.nmi_we   = 1'b1;
                ent.nmi_pc   = cur_pc;
                ent.nmi_psw  = cur_psw;
            end
            TAKE_IRQ: begin
                ent.redirect = 1'b1;
                ent.pc       = {16'h0000, vec};
                ent.psw      = psw_on_irq(cur_psw);
                ent.cause    = {cur_cause[31:16], vec};
                ent.irq_we   = 1'b1;
                ent.irq_pc   = cur_pc;
                ent.irq_psw  = cur_psw;
            end
            default: ent = '0;
        endcase
    end

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import intc_pkg::*;
#(
    parameter int NUM_IRQ = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reset_req,
    input  logic               nmi_req,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [31:0]        cur_pc,
    input  logic [31:0]        cur_psw,
    input  logic [31:0]        cur_cause,
    output logic               redirect_valid,
    output logic [31:0]        redirect_pc,
    output logic [31:0]        psw_next,
    output logic [31:0]        cause_next,
    output logic               nmi_bk_we,
    output logic [31:0]        nmi_bk_pc,
    output logic [31:0]        nmi_bk_psw,
    output logic               irq_bk_we,
    output logic [31:0]        irq_bk_pc,
    output logic [31:0]        irq_bk_psw
);

    logic               nmi_eff;
    logic [NUM_IRQ-1:0] irq_eff;
    logic [NUM_IRQ-1:0] grant;
    logic               nmi_take;
    take_e              kind;
    entry_t             ent;
    entry_t             q;

    assign nmi_take = (kind == TAKE_NMI);

    intc_pending #(.W(1)) u_nmi_hold (
        .clk     (clk),
        .rst     (rst),
        .clr_all (reset_req),
        .req     (nmi_req),
        .take    (nmi_take),
        .eff     (nmi_eff)
    );

    intc_pending #(.W(NUM_IRQ)) u_irq_hold (
        .clk     (clk),
        .rst     (rst),
        .clr_all (reset_req),
        .req     (irq_req),
        .take    (grant),
        .eff     (irq_eff)
    );

    intc_select #(.N(NUM_IRQ)) u_select (
        .reset_req (reset_req),
        .busy      (q.redirect),
        .np_flag   (cur_psw[PSW_NP_BIT]),
        .id_flag   (cur_psw[PSW_ID_BIT]),
        .nmi_eff   (nmi_eff),
        .irq_eff   (irq_eff),
        .kind      (kind),
        .grant     (grant)
    );

    intc_frame #(.N(NUM_IRQ)) u_frame (
        .kind      (kind),
        .grant     (grant),
        .cur_pc    (cur_pc),
        .cur_psw   (cur_psw),
        .cur_cause (cur_cause),
        .ent       (ent)
    );

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= ent;
    end

    assign redirect_valid = q.redirect;
    assign redirect_pc    = q.pc;
    assign psw_next       = q.psw;
    assign cause_next     = q.cause;
    assign nmi_bk_we      = q.nmi_we;
    assign nmi_bk_pc      = q.nmi_pc;
    assign nmi_bk_psw     = q.nmi_psw;
    assign irq_bk_we      = q.irq_we;
    assign irq_bk_pc      = q.irq_pc;
    assign irq_bk_psw     = q.irq_psw;

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |=> !redirect_valid); // R9

    AST_NMI_GATED: assert property (@(posedge clk) disable iff (rst)
        nmi_bk_we |-> !$past(cur_psw[PSW_NP_BIT])); // R2

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_bk_we |-> (!$past(cur_psw[PSW_NP_BIT]) && !$past(cur_psw[PSW_ID_BIT]))); // R5

    AST_ONE_BACKUP: assert property (@(posedge clk) disable iff (rst)
        $onehot0({nmi_bk_we, irq_bk_we})); // R10

    AST_RESET_WINS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(reset_req)) |->
            (redirect_valid && redirect_pc == RESET_PC && !nmi_bk_we && !irq_bk_we)); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !redirect_valid |-> (psw_next == '0 && cause_next == '0 && !nmi_bk_we && !irq_bk_we)); // R10

endmodule

// File: tb/sim_irq_entry_ctrl.sv
module sim_irq_entry_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reset_req = 1'b0;
    logic         nmi_req = 1'b0;
    logic [N-1:0] irq_req = '0;
    logic [31:0]  cur_pc = 32'h0000_1000;
    logic [31:0]  cur_psw = 32'h0000_0020;
    logic [31:0]  cur_cause = 32'h0;

    logic         redirect_valid, nmi_bk_we, irq_bk_we;
    logic [31:0]  redirect_pc, psw_next, cause_next;
    logic [31:0]  nmi_bk_pc, nmi_bk_psw, irq_bk_pc, irq_bk_psw;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    bit    follow = 1;
    string tag = "R11";

    // expected outputs from the behavioural model
    logic        x_valid, x_nwe, x_iwe;
    logic [31:0] x_pc, x_psw, x_cause, x_npc, x_npsw, x_ipc, x_ipsw;
    bit          m_nmi;
    bit          m_irq [N];

    irq_entry_ctrl #(.NUM_IRQ(N)) u0 (
        .clk            (clk),
        .rst            (rst),
        .reset_req      (reset_req),
        .nmi_req        (nmi_req),
        .irq_req        (irq_req),
        .cur_pc         (cur_pc),
        .cur_psw        (cur_psw),
        .cur_cause      (cur_cause),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .psw_next       (psw_next),
        .cause_next     (cause_next),
        .nmi_bk_we      (nmi_bk_we),
        .nmi_bk_pc      (nmi_bk_pc),
        .nmi_bk_psw     (nmi_bk_psw),
        .irq_bk_we      (irq_bk_we),
        .irq_bk_pc      (irq_bk_pc),
        .irq_bk_psw     (irq_bk_psw)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic clear_expect();
        x_valid = 0; x_nwe = 0; x_iwe = 0;
        x_pc = 0; x_psw = 0; x_cause = 0;
        x_npc = 0; x_npsw = 0; x_ipc = 0; x_ipsw = 0;
    endtask

    always @(posedge clk) begin : model
        bit          en;
        bit          ei [N];
        bit          was_busy;
        int          sel;
        logic [31:0] v;
        if (rst) begin
            clear_expect();
            m_nmi = 0;
            for (int i = 0; i < N; i++) m_irq[i] = 0;
        end else begin
            en = m_nmi | nmi_req;
            for (int i = 0; i < N; i++) ei[i] = m_irq[i] | irq_req[i];
            was_busy = x_valid;
            clear_expect();
            if (reset_req) begin
                x_valid = 1; x_pc = 0; x_psw = 32'h20; x_cause = 0;
                m_nmi = 0;
                for (int i = 0; i < N; i++) m_irq[i] = 0;
            end else begin
                sel = -1;
                if (!was_busy && en && !cur_psw[7]) begin
                    x_valid = 1; x_pc = 32'h10;
                    x_psw = (cur_psw | 32'hA0) & ~32'h40;
                    x_cause = {16'h0010, cur_cause[15:0]};
                    x_nwe = 1; x_npc = cur_pc; x_npsw = cur_psw;
                    en = 0;
                end else if (!was_busy && !cur_psw[7] && !cur_psw[5]) begin
                    for (int i = 0; i < N; i++)
                        if (ei[i] && sel < 0) sel = i;
                end
                if (sel >= 0) begin
                    v = 32'h80 + 32'h10 * sel;
                    x_valid = 1; x_pc = v;
                    x_psw = (cur_psw | 32'h20) & ~32'h40;
                    x_cause = {cur_cause[31:16], v[15:0]};
                    x_iwe = 1; x_ipc = cur_pc; x_ipsw = cur_psw;
                    ei[sel] = 0;
                end
                m_nmi = en;
                for (int i = 0; i < N; i++) m_irq[i] = ei[i];
            end
        end
    end

    task automatic chk(input string f, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, f, act, exp);
        end
    endtask

    task automatic compare();
        chk("redirect_valid", {31'b0, redirect_valid}, {31'b0, x_valid});
        chk("redirect_pc", redirect_pc, x_pc);
        chk("psw_next", psw_next, x_psw);
        chk("cause_next", cause_next, x_cause);
        chk("nmi_bk_we", {31'b0, nmi_bk_we}, {31'b0, x_nwe});
        chk("nmi_bk_pc", nmi_bk_pc, x_npc);
        chk("nmi_bk_psw", nmi_bk_psw, x_npsw);
        chk("irq_bk_we", {31'b0, irq_bk_we}, {31'b0, x_iwe});
        chk("irq_bk_pc", irq_bk_pc, x_ipc);
        chk("irq_bk_psw", irq_bk_psw, x_ipsw);
    endtask

    // one cycle: compare at the falling edge, act as the core, drop pulses
    task automatic step(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            compare();
            if (follow && redirect_valid) begin
                cur_pc    = redirect_pc;
                cur_psw   = psw_next;
                cur_cause = cause_next;
            end else begin
                cur_pc = cur_pc + 32'd4;
            end
            nmi_req   = 0;
            irq_req   = '0;
            reset_req = 0;
        end
    endtask

    initial begin
        // R11: block reset, outputs zero
        tag = "R11";
        rst = 1;
        step(3);
        rst = 0;
        step(2);

        // R5: line 2 masked by interrupt-disable, stays latched
        tag = "R5";
        irq_req = 6'b000100;
        step(4);

        // R6: unmask, vector 0xA0 taken with backup write
        tag = "R6";
        cur_psw = 32'h0000_0001;
        cur_cause = 32'hABCD_0000;
        step(3);

        // R7: lines 4 and 1 together, lowest index first
        tag = "R7";
        irq_req = 6'b010010;
        step(1);
        cur_psw = 32'h0;
        step(2);
        cur_psw = 32'h0;
        step(2);

        // R2 and R3: NMI taken with interrupt-disable set
        tag = "R2";
        cur_psw = 32'h0000_0061;
        cur_cause = 32'h1234_5678;
        nmi_req = 1;
        step(1);
        tag = "R3";
        step(1);

        // R4: repeated NMIs while NMI-pending set, one later delivery
        tag = "R4";
        nmi_req = 1;
        step(2);
        nmi_req = 1;
        step(1);
        irq_req = 6'b000001;
        nmi_req = 1;
        step(3);
        cur_psw = 32'h0;
        step(4);
        cur_psw = 32'h0;
        step(2);

        // R9: core ignores strobes, lockout cycle spaces acceptances
        tag = "R9";
        follow = 0;
        cur_psw = 32'h0;
        irq_req = 6'b000011;
        step(4);
        follow = 1;

        // R8: NMI and maskable in the same cycle
        tag = "R8";
        cur_psw = 32'h0;
        nmi_req = 1;
        irq_req = 6'b100000;
        step(2);
        cur_psw = 32'h0;
        step(2);

        // R1: reset request discards held work
        tag = "R1";
        cur_psw = 32'h0000_0080;
        nmi_req = 1;
        irq_req = 6'b001000;
        step(1);
        reset_req = 1;
        step(2);
        cur_psw = 32'h0;
        step(3);
        nmi_req = 1;
        reset_req = 1;
        step(2);

        // R10: idle outputs quiet
        tag = "R10";
        cur_psw = 32'h0000_0020;
        step(3);

        // R11: block reset mid-run drops a held line
        tag = "R11";
        irq_req = 6'b000001;
        step(1);
        rst = 1;
        step(1);
        rst = 0;
        cur_psw = 32'h0;
        step(3);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule